// File: doc/BRIEF.md
# Host Transmit Queue Write Port

This block sits between a 32-bit host register bus and an Ethernet MAC transmitter. The host opens a frame with a control write that carries a frame tag and option bits. It then writes the frame length in bytes and pushes the payload one 32-bit word at a time. The block stores the words in a small queue and sends them to the transmitter as a byte stream with valid/ready handshaking. The programmed length decides how many lanes of the final word are sent and where the last-byte flag goes. The frame tag and options travel beside each byte.

Two host mistakes are caught. If a new control write arrives while the open frame still expects bytes, the block raises an under-run and removes that frame's words from the queue. If the transmitter had already started on that frame, the block also pulses an abort to the transmitter. If a data word arrives after the byte count is used up, or when the queue has no room, the block raises an over-run and drops the word. Both flags are sticky. Each has a mask bit and is cleared by writing 1. A separate status queue receives one word from the transmitter per finished frame. The host pops it through a register. When that queue is full, the entries already stored are kept and new arrivals are discarded.

Top module: `txq_host_port`

## Requirements
- R1: After reset the stream is idle (tx_valid low), the interrupt output is low, the flag register (address 4) reads 0 and the status register (address 3) reads 0.
- R2: A write to address 0 latches the frame tag from bits [ID_W-1:0] and the options from the next OPT_W bits. With the defaults, the tag is bits 7:0 and the options are bits 11:8, where option bit 0 (word bit 8) disables the deferral timeout. Every byte of the frame carries these values on tx_id and tx_opts.
- R3: A write to address 1 sets the frame length in bytes. Words written to address 2 go out little-endian: bits 7:0 first, then 15:8, 23:16 and 31:24. Exactly that many bytes are sent, and tx_last is high on the final byte only.
- R4: When the length is not a multiple of four, only the lowest (length mod 4) lanes of the final word are sent.
- R5: A data write made when no bytes remain (the count is used up, or no length has been written since the control write) sets over-run flag bit 1 and is not sent.
- R6: While the stream is stalled, the block holds DATA_DEPTH+1 words. A further data write sets over-run flag bit 1 and is dropped.
- R7: A control write while the open frame still expects bytes sets under-run flag bit 0 and removes that frame's stored words. If the transmitter already holds a word of that frame, tx_abort is high for one cycle, the cycle after the write, and the stream is idle in that cycle.
- R8: An under-run leaves earlier, completely written frames untouched: they are still sent in full and no abort is raised.
- R9: The irq output is high when any flag bit is set together with the same bit of the mask register (address 5). Writing 1s to address 4 clears those flag bits.
- R10: Each st_valid pulse stores one status word. A read of address 3 returns the oldest one, formatted as bit 31 Done=1, bit 30 good, tag in bits [ID_W-1:0], and removes it. A read with nothing stored returns 0.
- R11: When the status queue is full, arriving status words are discarded and the stored ones are kept in order.
- R12: While tx_ready is low, tx_valid and tx_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_addr | input | 3 | Register address (0 control, 1 length, 2 data, 3 status, 4 flags, 5 mask) |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read data, valid the cycle after hst_rd |
| irq | output | 1 | Masked interrupt |
| tx_valid | output | 1 | Byte stream valid |
| tx_ready | input | 1 | Byte stream ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_id | output | ID_W | Frame tag of the current byte |
| tx_opts | output | OPT_W | Frame options; bit 0 disables deferral timeout |
| tx_abort | output | 1 | One-cycle pulse: frame in progress was aborted |
| st_valid | input | 1 | Transmitter reports a finished frame |
| st_id | input | ID_W | Tag of the finished frame |
| st_ok | input | 1 | Finished frame was sent without error |

## Verification
The bench builds the block with DATA_DEPTH=8 and STAT_DEPTH=4, keeping the default tag and option widths. The shallow word queue lets a stalled ten-word frame reach the capacity over-run and then an under-run that catches a word already held by the transmitter. The four-entry status queue lets six status reports overfill it, which shows that the stored words are kept and the late ones dropped. Lengths of 5, 6 and 8 cover partial and full final words. A toggling ready signal covers the stall behaviour.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_SIZE = 3'd1,
    A_DATA = 3'd2,
    A_STAT = 3'd3,
    A_FLAG = 3'd4,
    A_MASK = 3'd5
  } reg_addr_e;

  localparam int FLAG_UNDER = 0;
  localparam int FLAG_OVER  = 1;

  // Number of lanes a data word carries, given the bytes still expected.
  function automatic logic [2:0] lanes_for(input logic [31:0] left);
    if (left >= 32'd4) return 3'd4;
    return left[2:0];
  endfunction

  // Byte of a little-endian word selected by lane index.
  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    logic [31:0] s;
    s = w >> {lane, 3'b000};
    return s[7:0];
  endfunction

  // Words to take back from the queue tail on an under-run.
  function automatic logic [31:0] words_to_drop(input logic [31:0] open_words,
                                                input logic [31:0] stored);
    return (open_words < stored) ? open_words : stored;
  endfunction

endpackage

// File: rtl/txq_word_fifo.sv
module txq_word_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  input  logic          rewind,
  input  logic [CW-1:0] drop,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign count = cnt;
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (rewind) begin
      wp  <= wp - drop[AW-1:0];
      cnt <= cnt - drop;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  // R6
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R7
  rewind_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |-> (!push && !pop && drop <= cnt));
endmodule

// File: rtl/txq_stat_fifo.sv
module txq_stat_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R11
  keep_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (full && $stable(rp)));
endmodule

// File: rtl/txq_byte_ser.sv
module txq_byte_ser #(
  parameter int ID_W  = 8,
  parameter int OPT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             have_word,
  input  logic [31:0]      word,
  input  logic [2:0]       nlanes,
  input  logic             wlast,
  input  logic [ID_W-1:0]  wid,
  input  logic [OPT_W-1:0] wopts,
  output logic             take,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic [ID_W-1:0]  tx_id,
  output logic [OPT_W-1:0] tx_opts
);
  import txq_pkg::*;

  logic             busy;
  logic [31:0]      wd;
  logic [1:0]       idx;
  logic [2:0]       nb;
  logic             wl;
  logic [ID_W-1:0]  id_q;
  logic [OPT_W-1:0] op_q;
  logic             at_end;

  assign at_end   = ({1'b0, idx} == (nb - 3'd1));
  assign take     = have_word && !kill && (!busy || (tx_ready && at_end));
  assign tx_valid = busy;
  assign tx_data  = lane_byte(wd, idx);
  assign tx_last  = busy && wl && at_end;
  assign tx_id    = id_q;
  assign tx_opts  = op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wd   <= '0;
      idx  <= '0;
      nb   <= 3'd4;
      wl   <= 1'b0;
      id_q <= '0;
      op_q <= '0;
    end else if (kill) begin
      busy <= 1'b0;
    end else if (take) begin
      busy <= 1'b1;
      wd   <= word;
      idx  <= '0;
      nb   <= nlanes;
      wl   <= wlast;
      id_q <= wid;
      op_q <= wopts;
    end else if (busy && tx_ready) begin
      if (at_end) busy <= 1'b0;
      else        idx  <= idx + 1'b1;
    end
  end

  // R12
  hold_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_ready && !kill) |=> (tx_valid && $stable(tx_data) && $stable(idx)));
  // R4
  lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (nlanes != 3'd0 && nlanes <= 3'd4));
endmodule

// File: rtl/txq_host_port.sv
module txq_host_port #(
  parameter int ID_W       = 8,
  parameter int OPT_W      = 4,
  parameter int SIZE_W     = 16,
  parameter int DATA_DEPTH = 16,
  parameter int STAT_DEPTH = 128,
  localparam int EW        = 32 + 3 + 1 + ID_W + OPT_W,
  localparam int QCW       = $clog2(DATA_DEPTH) + 1,
  localparam int SW        = ID_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_wr,
  input  logic             hst_rd,
  input  logic [2:0]       hst_addr,
  input  logic [31:0]      hst_wdata,
  output logic [31:0]      hst_rdata,
  output logic             irq,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic [ID_W-1:0]  tx_id,
  output logic [OPT_W-1:0] tx_opts,
  output logic             tx_abort,
  input  logic             st_valid,
  input  logic [ID_W-1:0]  st_id,
  input  logic             st_ok
);
  import txq_pkg::*;

  // Open-frame state
  logic [SIZE_W-1:0] bytes_left;
  logic [SIZE_W-1:0] open_words;
  logic [ID_W-1:0]   id_q;
  logic [OPT_W-1:0]  op_q;
  logic [1:0]        flags, mask;
  logic [31:0]       rdata_q;
  logic              abort_q;

  // Named events
  logic ev_ctrl, ev_size, ev_data, ev_under, ev_over, ev_store, ev_kill, ev_stat_pop;
  logic [2:0] lanes;

  // Word queue wiring
  logic [EW-1:0]  q_din, q_dout;
  logic           q_pop, q_empty, q_full;
  logic [QCW-1:0] q_count, q_drop;

  // Status queue wiring
  logic [SW-1:0] s_dout;
  logic          s_empty, s_full;

  assign ev_ctrl     = hst_wr && (hst_addr == A_CTRL);
  assign ev_size     = hst_wr && (hst_addr == A_SIZE);
  assign ev_data     = hst_wr && (hst_addr == A_DATA);
  assign ev_under    = ev_ctrl && (bytes_left != '0);
  assign ev_over     = ev_data && ((bytes_left == '0) || q_full);
  assign ev_store    = ev_data && !ev_over;
  assign ev_stat_pop = hst_rd && (hst_addr == A_STAT) && !s_empty;
  assign lanes       = lanes_for(32'(bytes_left));
  assign q_drop      = QCW'(words_to_drop(32'(open_words), 32'(q_count)));
  assign ev_kill     = ev_under && (32'(open_words) > 32'(q_count));

  assign q_din = {op_q, id_q, (bytes_left <= SIZE_W'(4)), lanes, hst_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_left <= '0;
      open_words <= '0;
      id_q       <= '0;
      op_q       <= '0;
    end else if (ev_ctrl) begin
      bytes_left <= '0;
      open_words <= '0;
      id_q       <= hst_wdata[ID_W-1:0];
      op_q       <= hst_wdata[ID_W +: OPT_W];
    end else if (ev_size) begin
      bytes_left <= hst_wdata[SIZE_W-1:0];
    end else if (ev_store) begin
      bytes_left <= bytes_left - SIZE_W'(lanes);
      open_words <= open_words + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      mask    <= '0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= ev_kill;
      if (hst_wr && hst_addr == A_FLAG) flags <= flags & ~hst_wdata[1:0];
      if (ev_under) flags[FLAG_UNDER] <= 1'b1;
      if (ev_over)  flags[FLAG_OVER]  <= 1'b1;
      if (hst_wr && hst_addr == A_MASK) mask <= hst_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (hst_rd) begin
      unique case (hst_addr)
        A_STAT:  rdata_q <= s_empty ? 32'd0
                          : (32'h8000_0000 | (32'(s_dout[ID_W]) << 30) | 32'(s_dout[ID_W-1:0]));
        A_FLAG:  rdata_q <= {30'd0, flags};
        A_MASK:  rdata_q <= {30'd0, mask};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign hst_rdata = rdata_q;
  assign irq       = |(flags & mask);
  assign tx_abort  = abort_q;

  txq_word_fifo #(.W(EW), .DEPTH(DATA_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n),
    .push(ev_store), .din(q_din),
    .pop(q_pop), .dout(q_dout),
    .rewind(ev_under), .drop(q_drop),
    .count(q_count), .empty(q_empty), .full(q_full)
  );

  txq_byte_ser #(.ID_W(ID_W), .OPT_W(OPT_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .kill(ev_kill),
    .have_word(!q_empty && !ev_under),
    .word(q_dout[31:0]),
    .nlanes(q_dout[34:32]),
    .wlast(q_dout[35]),
    .wid(q_dout[36 +: ID_W]),
    .wopts(q_dout[36+ID_W +: OPT_W]),
    .take(q_pop),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last),
    .tx_id(tx_id), .tx_opts(tx_opts)
  );

  txq_stat_fifo #(.W(SW), .DEPTH(STAT_DEPTH)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .push(st_valid), .din({st_ok, st_id}),
    .pop(ev_stat_pop), .dout(s_dout),
    .empty(s_empty), .full(s_full)
  );

  // R7
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_under |=> flags[FLAG_UNDER]);
  // R5
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_over |=> flags[FLAG_OVER]);
  // R7
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> !tx_valid);
  // R8
  no_kill_with_backlog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_under && q_count >= QCW'(open_words)) |=> !tx_abort);
endmodule

// File: tb/txq_host_port_test.sv
`timescale 1ns/1ps
module txq_host_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_wr = 0, hst_rd = 0;
  logic [2:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0, hst_rdata;
  logic irq, tx_valid, tx_ready, tx_last, tx_abort;
  logic [7:0] tx_data, tx_id;
  logic [3:0] tx_opts;
  logic st_valid = 0, st_ok = 0;
  logic [7:0] st_id = 0;
  logic rdy_hold = 0, rdy_jit = 0, ph = 0;

  int errors = 0, checks = 0;
  logic [7:0] cap [0:255];
  int ncap = 0, nlast = 0, lastidx = -1, nabort = 0;
  logic [7:0] capid;
  logic [3:0] capopt;

  always #4 clk = ~clk;
  always @(posedge clk) ph <= ~ph;
  assign tx_ready = rdy_hold ? 1'b0 : (rdy_jit ? ph : 1'b1);

  txq_host_port #(.DATA_DEPTH(8), .STAT_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_id(tx_id),
    .tx_opts(tx_opts), .tx_abort(tx_abort), .st_valid(st_valid), .st_id(st_id), .st_ok(st_ok));

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      cap[ncap[7:0]] = tx_data;
      if (tx_last) begin nlast++; lastidx = ncap; end
      capid = tx_id; capopt = tx_opts;
      ncap++;
    end
    if (tx_abort) nabort++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #1;
    hst_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    hst_rd = 1; hst_addr = a;
    @(posedge clk); #1;
    hst_rd = 0; d = hst_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] wordat(input logic [7:0] b);
    return {b + 8'd3, b + 8'd2, b + 8'd1, b};
  endfunction

  task automatic clear_cap();
    ncap = 0; nlast = 0; lastidx = -1; nabort = 0;
  endtask

  task automatic send(input logic [7:0] id, input logic [3:0] op, input int size,
                      input logic [7:0] base, input int nwords);
    wr(3'd0, {20'd0, op, id});
    wr(3'd1, size);
    for (int k = 0; k < nwords; k++) wr(3'd2, wordat(base + 8'(4 * k)));
  endtask

  task automatic chk_bytes(input int from, input logic [7:0] base, input int n, input string tag);
    for (int i = 0; i < n; i++)
      chk(cap[from + i] == base + 8'(i), tag, cap[from + i], base + 8'(i));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rd(3'd4, d); chk(d == 0, "R1 flags", d, 0);
    rd(3'd3, d); chk(d == 0, "R1 status", d, 0);
  endtask

  task automatic t_basic();
    clear_cap();
    send(8'h21, 4'h1, 8, 8'h10, 2);
    idle(20);
    chk(ncap == 8, "R3 byte count", ncap, 8);
    chk_bytes(0, 8'h10, 8, "R3 little-endian order");
    chk(nlast == 1 && lastidx == 7, "R3 last flag", lastidx, 7);
    chk(capid == 8'h21, "R2 tx_id", capid, 8'h21);
    chk(capopt == 4'h1, "R2 tx_opts no-deferral bit", capopt, 1);
  endtask

  task automatic t_partial();
    clear_cap();
    send(8'h22, 4'h6, 6, 8'h40, 2);
    idle(20);
    chk(ncap == 6, "R4 size6 count", ncap, 6);
    chk_bytes(0, 8'h40, 6, "R4 size6 bytes");
    chk(lastidx == 5, "R4 size6 last", lastidx, 5);
    chk(capopt == 4'h6, "R2 opts 6", capopt, 6);
    clear_cap();
    send(8'h23, 4'h0, 5, 8'h50, 2);
    idle(20);
    chk(ncap == 5 && lastidx == 4, "R4 size5 count", ncap, 5);
    chk_bytes(0, 8'h50, 5, "R4 size5 bytes");
  endtask

  task automatic t_stall();
    clear_cap();
    rdy_jit = 1;
    send(8'h24, 4'h0, 12, 8'h60, 3);
    idle(40);
    rdy_jit = 0;
    chk(ncap == 12 && nlast == 1, "R12 stalled count", ncap, 12);
    chk_bytes(0, 8'h60, 12, "R12 stalled bytes");
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    clear_cap();
    send(8'h25, 4'h0, 4, 8'h70, 2);
    idle(12);
    chk(ncap == 4, "R5 extra word not sent", ncap, 4);
    rd(3'd4, d); chk(d == 2, "R5 overrun flag", d, 2);
    chk(irq == 0, "R9 masked irq low", irq, 0);
    wr(3'd5, 32'd2);
    chk(irq == 1, "R9 unmasked irq high", irq, 1);
    wr(3'd4, 32'd2);
    rd(3'd4, d); chk(d == 0, "R9 write-one clear", d, 0);
    chk(irq == 0, "R9 irq after clear", irq, 0);
    wr(3'd0, 32'h26);
    wr(3'd2, 32'h1234_5678);
    idle(8);
    rd(3'd4, d); chk(d == 2, "R5 data with no length", d, 2);
    chk(ncap == 4, "R5 no-length word not sent", ncap, 4);
    wr(3'd4, 32'd3);
    wr(3'd5, 32'd0);
  endtask

  task automatic t_full_abort();
    logic [31:0] d;
    clear_cap();
    rdy_hold = 1;
    send(8'h30, 4'h0, 40, 8'h00, 10);
    rd(3'd4, d); chk(d == 2, "R6 full queue overrun", d, 2);
    wr(3'd4, 32'd3);
    wr(3'd0, 32'h31);
    chk(tx_abort == 1, "R7 abort pulse", tx_abort, 1);
    chk(tx_valid == 0, "R7 stream idle", tx_valid, 0);
    idle(2);
    chk(nabort == 1, "R7 single abort", nabort, 1);
    rd(3'd4, d); chk(d == 1, "R7 underrun flag", d, 1);
    wr(3'd4, 32'd3);
    wr(3'd1, 32'd4);
    wr(3'd2, wordat(8'h80));
    rdy_hold = 0;
    idle(12);
    chk(ncap == 4, "R7 only new frame sent", ncap, 4);
    chk_bytes(0, 8'h80, 4, "R7 new frame bytes");
    chk(capid == 8'h31, "R7 new frame tag", capid, 8'h31);
  endtask

  task automatic t_keep();
    logic [31:0] d;
    clear_cap();
    rdy_hold = 1;
    send(8'h41, 4'h0, 4, 8'h90, 1);
    send(8'h42, 4'h0, 8, 8'hA0, 1);
    send(8'h43, 4'h0, 4, 8'hB0, 1);
    rdy_hold = 0;
    idle(16);
    rd(3'd4, d); chk(d == 1, "R8 underrun flag", d, 1);
    chk(nabort == 0, "R8 no abort", nabort, 0);
    chk(ncap == 8 && nlast == 2, "R8 two frames sent", ncap, 8);
    chk_bytes(0, 8'h90, 4, "R8 earlier frame intact");
    chk_bytes(4, 8'hB0, 4, "R8 following frame");
    wr(3'd4, 32'd3);
  endtask

  task automatic push_stat(input logic [7:0] id, input logic ok);
    st_valid = 1; st_id = id; st_ok = ok;
    @(posedge clk); #1;
    st_valid = 0;
  endtask

  task automatic t_status();
    logic [31:0] d;
    push_stat(8'h01, 1); push_stat(8'h02, 0); push_stat(8'h03, 1);
    rd(3'd3, d); chk(d == 32'hC000_0001, "R10 status 1", d, 32'hC000_0001);
    rd(3'd3, d); chk(d == 32'h8000_0002, "R10 status 2", d, 32'h8000_0002);
    rd(3'd3, d); chk(d == 32'hC000_0003, "R10 status 3", d, 32'hC000_0003);
    rd(3'd3, d); chk(d == 0, "R10 empty read", d, 0);
    for (int i = 0; i < 6; i++) push_stat(8'h11 + 8'(i), 1);
    for (int i = 0; i < 4; i++) begin
      rd(3'd3, d);
      chk(d == (32'hC000_0011 + 32'(i)), "R11 oldest kept", d, 32'hC000_0011 + i);
    end
    rd(3'd3, d); chk(d == 0, "R11 newer dropped", d, 0);
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_partial();
    t_stall();
    t_overrun();
    t_full_abort();
    t_keep();
    t_status();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule